// File: doc/BRIEF.md
# Word-Staged I2C Bus Master

This block is a register-programmed I2C master. Each start command runs one complete bus transaction: a START, an address byte and one to four data bytes, then a STOP. The target is chosen with a 7-bit address. Software first loads the target address and up to four write bytes, which are packed into one 32-bit word. It then writes the control register, which holds the enable, the direction, the byte counts and the start bit. Bytes read from the target come back packed into one 32-bit word.

Completion and failure are recorded in two sticky status flags, and software clears each one by writing one to it. An enable mask selects which flags drive the interrupt output. The bus clock is derived in two steps. A fixed prescaler divides the core clock by eight, and a programmable divider then sets the length of each SCL half period. A bus timeout can be enabled. It turns a target that holds SCL low for too long into an error.

The transfer engine is a state machine with seven states. IDLE moves to START on an accepted start command. START moves to SEND_BITS. SEND_BITS moves to GET_ACK after eight bits. GET_ACK moves to SEND_BITS for the next write byte, to RECV_BITS after the address of a read, or to STOP after a NACK or the last write byte. RECV_BITS moves to PUT_ACK after eight bits. PUT_ACK moves back to RECV_BITS, or to STOP after the last byte. STOP returns to IDLE. A timeout in any bit phase or in STOP goes straight to IDLE.

Top module: `i2c_word_master`

## Requirements
- R1: After reset every register reads zero, `scl_oe` and `sda_oe` are low, and `irq` is low.
- R2: A write transaction (control bit 4 = 1) first sends the address byte {target[7:1], 0}. It then sends (control[3:2] + 1) bytes from the write word, least significant byte first (byte j at bits 8j+7..8j), ends with a STOP, and sets status bit 1 (done).
- R3: A read transaction (control bit 4 = 0) sends the address byte {target[7:1], 1} and receives (control[1:0] + 1) bytes. The first byte received lands in read word bits 7..0. The master ACKs every byte except the last, which it NACKs, and the transaction ends with a STOP and status bit 1.
- R4: A NACK after the address byte or after any write byte ends the transaction with a STOP and sets status bit 0 (error) instead of status bit 1.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when a status bit is set whose enable bit (same position in the enable register) is set.
- R6: When a flag is set and cleared by software in the same cycle, the set wins and the flag stays 1.
- R7: Control bit 31 enables the controller. Control bit 6 starts a transaction and always reads back 0 one cycle after it is written. A start given while the controller is disabled or a transaction is running is ignored, and the running transaction keeps the byte count it started with.
- R8: When timing bit 7 is set and SCL stays low during a high phase for more than 2 × timing[6:0] half periods, the transaction is abandoned and status bit 0 is set.
- R9: Each SCL half period lasts (timing[17:8] + 1) × 8 core clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word index: 0 control, 1 timing, 2 target, 3 write word, 4 read word, 5 status, 6 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| scl_i | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The completion flag can be set by the transfer engine in the same cycle that a write-one-to-clear of the same bit arrives on the register bus. To provoke this, the bench watches the bus lines and recognises the STOP edge, which appears one cycle before the flag is set. On that exact cycle it drives a clear of the done bit. The flag must still read 1 afterwards and the interrupt must stay asserted. A second overlap comes from a start command issued while a transaction is still running. That case is judged by the number of bytes seen on the bus and by the absence of any second START.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_SEND, S_GETACK, S_RECV, S_PUTACK, S_STOP
    } xfer_state_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_TIME = 3'd1;
    localparam logic [2:0] ADR_TADR = 3'd2;
    localparam logic [2:0] ADR_WDAT = 3'd3;
    localparam logic [2:0] ADR_RDAT = 3'd4;
    localparam logic [2:0] ADR_STAT = 3'd5;
    localparam logic [2:0] ADR_IEN  = 3'd6;
endpackage

// File: rtl/i2cw_tick_gen.sv
module i2cw_tick_gen #(
    parameter int PRESCALE = 8,
    parameter int DIV_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0]    pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             ce;

    assign ce   = (pre_cnt == PW'(PRESCALE - 1));
    assign tick = ce && (div_cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= ce ? '0 : pre_cnt + 1'b1;
            if (ce) div_cnt <= tick ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cw_xfer_fsm.sv
module i2cw_xfer_fsm
    import i2cw_pkg::*;
#(
    parameter int TMO_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             dir_wr,
    input  logic [1:0]       wcnt,
    input  logic [1:0]       rcnt,
    input  logic [6:0]       taddr,
    input  logic [31:0]      wdata,
    input  logic             tmo_en,
    input  logic [TMO_W-1:0] tmo_len,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done_p,
    output logic             err_p,
    output logic [31:0]      rdata
);
    xfer_state_e      state;
    logic             hi, wr_q, addr_ph, fail;
    logic [2:0]       bitc;
    logic [1:0]       idx, last;
    logic [7:0]       sh;
    logic [31:0]      wbuf;
    logic [TMO_W:0]   stall;
    logic             bit_end, stalled;

    assign bit_end = tick && hi && scl_i;
    assign stalled = tick && hi && !scl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; hi <= 1'b1; wr_q <= 1'b0; addr_ph <= 1'b0;
            fail <= 1'b0; bitc <= '0; idx <= '0; last <= '0; sh <= '0;
            wbuf <= '0; stall <= '0; done_p <= 1'b0; err_p <= 1'b0;
            rdata <= '0;
        end else begin
            done_p <= 1'b0;
            err_p  <= 1'b0;
            if (state != S_IDLE && state != S_START) begin
                if (tick && !hi) begin
                    hi    <= 1'b1;
                    stall <= '0;
                end else if (stalled) begin
                    stall <= stall + 1'b1;
                    if (tmo_en && stall >= {tmo_len, 1'b0}) begin
                        err_p <= 1'b1;
                        state <= S_IDLE;
                        hi    <= 1'b1;
                    end
                end else if (bit_end) begin
                    hi <= 1'b0;
                end
            end
            unique case (state)
                S_IDLE: begin
                    hi <= 1'b1;
                    if (go) begin
                        wr_q    <= dir_wr;
                        last    <= dir_wr ? wcnt : rcnt;
                        sh      <= {taddr, ~dir_wr};
                        wbuf    <= wdata;
                        rdata   <= '0;
                        idx     <= '0;
                        bitc    <= 3'd7;
                        addr_ph <= 1'b1;
                        fail    <= 1'b0;
                        state   <= S_START;
                    end
                end
                S_START: if (tick) begin
                    hi    <= 1'b0;
                    state <= S_SEND;
                end
                S_SEND: if (bit_end) begin
                    sh <= {sh[6:0], 1'b0};
                    if (bitc == 3'd0) state <= S_GETACK;
                    else bitc <= bitc - 1'b1;
                end
                S_GETACK: if (bit_end) begin
                    bitc <= 3'd7;
                    if (sda_i) begin
                        fail  <= 1'b1;
                        state <= S_STOP;
                    end else if (addr_ph && !wr_q) begin
                        addr_ph <= 1'b0;
                        state   <= S_RECV;
                    end else if (addr_ph || idx != last) begin
                        if (!addr_ph) idx <= idx + 1'b1;
                        addr_ph <= 1'b0;
                        sh      <= wbuf[7:0];
                        wbuf    <= wbuf >> 8;
                        state   <= S_SEND;
                    end else begin
                        state <= S_STOP;
                    end
                end
                S_RECV: if (bit_end) begin
                    sh <= {sh[6:0], sda_i};
                    if (bitc == 3'd0) begin
                        rdata[{idx, 3'b000} +: 8] <= {sh[6:0], sda_i};
                        state <= S_PUTACK;
                    end else begin
                        bitc <= bitc - 1'b1;
                    end
                end
                S_PUTACK: if (bit_end) begin
                    bitc <= 3'd7;
                    if (idx == last) state <= S_STOP;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_RECV;
                    end
                end
                S_STOP: if (bit_end) begin
                    done_p <= !fail;
                    err_p  <= fail;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_oe = (state != S_IDLE) && (state != S_START) && !hi;
        busy   = (state != S_IDLE);
        unique case (state)
            S_IDLE:   sda_oe = 1'b0;
            S_START:  sda_oe = 1'b1;
            S_SEND:   sda_oe = ~sh[7];
            S_GETACK: sda_oe = 1'b0;
            S_RECV:   sda_oe = 1'b0;
            S_PUTACK: sda_oe = (idx != last);
            S_STOP:   sda_oe = 1'b1;
            default:  sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_word_master.sv
module i2c_word_master
    import i2cw_pkg::*;
#(
    parameter int PRESCALE = 8,
    parameter int DIV_W    = 10,
    parameter int TMO_W    = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        scl_i,
    output logic        scl_oe,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic        irq
);
    localparam int TIM_W = DIV_W + TMO_W + 1;

    logic             en_q, go_q, dir_q;
    logic [1:0]       wcnt_q, rcnt_q, st_q, ie_q;
    logic [TIM_W-1:0] tim_q;
    logic [6:0]       tadr_q;
    logic [31:0]      wdat_q, rdat;
    logic             tick, busy, done_p, err_p, wr_en;
    logic [1:0]       clr;

    assign wr_en = reg_sel && reg_wr;
    assign clr   = (wr_en && reg_addr == ADR_STAT) ? reg_wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; go_q <= 1'b0; dir_q <= 1'b0; wcnt_q <= '0;
            rcnt_q <= '0; st_q <= '0; ie_q <= '0; tim_q <= '0;
            tadr_q <= '0; wdat_q <= '0;
        end else begin
            go_q <= 1'b0;
            if (wr_en) begin
                unique case (reg_addr)
                    ADR_CTRL: begin
                        en_q   <= reg_wdata[31];
                        go_q   <= reg_wdata[6];
                        dir_q  <= reg_wdata[4];
                        wcnt_q <= reg_wdata[3:2];
                        rcnt_q <= reg_wdata[1:0];
                    end
                    ADR_TIME: tim_q  <= reg_wdata[TIM_W-1:0];
                    ADR_TADR: tadr_q <= reg_wdata[7:1];
                    ADR_WDAT: wdat_q <= reg_wdata;
                    ADR_IEN:  ie_q   <= reg_wdata[1:0];
                    default:  ;
                endcase
            end
            st_q[0] <= err_p  || (st_q[0] && !clr[0]);
            st_q[1] <= done_p || (st_q[1] && !clr[1]);
        end
    end

    assign irq = |(st_q & ie_q);

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL: reg_rdata = {en_q, 24'b0, go_q, 1'b0, dir_q, wcnt_q, rcnt_q};
            ADR_TIME: reg_rdata = {{(32-TIM_W){1'b0}}, tim_q};
            ADR_TADR: reg_rdata = {24'b0, tadr_q, 1'b0};
            ADR_WDAT: reg_rdata = wdat_q;
            ADR_RDAT: reg_rdata = rdat;
            ADR_STAT: reg_rdata = {30'b0, st_q};
            ADR_IEN:  reg_rdata = {30'b0, ie_q};
            default:  reg_rdata = '0;
        endcase
    end

    i2cw_tick_gen #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .div(tim_q[TIM_W-1 -: DIV_W]), .tick(tick)
    );

    i2cw_xfer_fsm #(.TMO_W(TMO_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .go(go_q && en_q && !busy), .dir_wr(dir_q), .wcnt(wcnt_q), .rcnt(rcnt_q),
        .taddr(tadr_q), .wdata(wdat_q), .tmo_en(tim_q[TMO_W]),
        .tmo_len(tim_q[TMO_W-1:0]), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done_p(done_p),
        .err_p(err_p), .rdata(rdat)
    );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ctl,
    input logic       clr_done,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [1:0] st_q,
    input logic [1:0] ie_q,
    input logic       go_q,
    input logic       busy,
    input logic       done_p,
    input logic       err_p
);
    a_r7_go_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && !wr_ctl) |=> !go_q);
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q != 2'b00));
    a_r6_done_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> st_q[1]);
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[1] && !clr_done) |=> st_q[1]);
    a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_p && err_p));
    a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_word_master i2cw_checker i_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(reg_sel && reg_wr && reg_addr == 3'd0),
    .clr_done(reg_sel && reg_wr && reg_addr == 3'd5 && reg_wdata[1]),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .st_q(st_q), .ie_q(ie_q),
    .go_q(go_q), .busy(busy), .done_p(done_p), .err_p(err_p)
);

// File: tb/test_i2c_word_master.sv
module test_i2c_word_master;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe, irq, scl_line, sda_line;
    logic tgt_low = 1'b0, stretch = 1'b0;

    always #10 clk = ~clk;
    assign scl_line = ~scl_oe & ~stretch;
    assign sda_line = ~sda_oe & ~tgt_low;

    i2c_word_master i_i2c_word_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe),
        .irq(irq)
    );

    localparam logic [31:0] EN = 32'h8000_0000, GO = 32'h40, DIRW = 32'h10;
    int n_chk = 0, n_fail = 0, n_starts = 0, n_bytes = 0, nack_at = -1;
    logic [7:0] exp_q[$];
    logic [7:0] tx_bytes[4];
    logic [3:0] mack_v;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int k = 0;
        while (!irq && k < 20000) begin @(negedge clk); k++; end
        check({req, " irq timeout"}, {31'b0, irq}, 32'h1);
    endtask

    task automatic start_write(input logic [6:0] a7, input logic [31:0] d, input int cnt, input int nb);
        exp_q.push_back({a7, 1'b0});
        for (int j = 0; j < nb; j++) exp_q.push_back(d[8*j +: 8]);
        wr(3'd2, {24'b0, a7, 1'b0});
        wr(3'd3, d);
        wr(3'd0, EN | GO | DIRW | 32'((cnt - 1) << 2));
    endtask

    task automatic start_read(input logic [6:0] a7, input int cnt);
        exp_q.push_back({a7, 1'b1});
        wr(3'd2, {24'b0, a7, 1'b0});
        wr(3'd0, EN | GO | 32'(cnt - 1));
    endtask

    // Monitor: bus target model and scoreboard consumer
    initial begin
        logic pscl = 1'b1, psda = 1'b1, in_xfer = 1'b0, tx_mode = 1'b0;
        logic rd_req = 1'b0, last_nack = 1'b0;
        logic [7:0] sh_in = '0, e;
        int bc = 0, nbyte = 0;
        forever begin
            @(negedge clk);
            if (scl_line && pscl && psda && !sda_line) begin
                in_xfer = 1'b1; bc = 0; nbyte = 0; tx_mode = 1'b0;
                tgt_low = 1'b0; last_nack = 1'b0; n_starts++;
            end else if (scl_line && pscl && !psda && sda_line) begin
                in_xfer = 1'b0; tgt_low = 1'b0;
            end else if (in_xfer && scl_line && !pscl) begin
                if (bc < 8) begin
                    if (!tx_mode) sh_in = {sh_in[6:0], sda_line};
                    bc++;
                    if (bc == 8 && !tx_mode) begin
                        n_bytes++;
                        if (exp_q.size() == 0) check("R2 unexpected bus byte", {24'b0, sh_in}, 32'hFFFF_FFFF);
                        else begin
                            e = exp_q.pop_front();
                            check("R2 bus byte", {24'b0, sh_in}, {24'b0, e});
                        end
                        if (nbyte == 0) rd_req = sh_in[0];
                    end
                end else begin
                    if (tx_mode) begin
                        mack_v[nbyte-1] = !sda_line;
                        last_nack = sda_line;
                    end
                    if (nbyte == 0) tx_mode = rd_req;
                    bc = 0; nbyte++;
                end
            end else if (in_xfer && !scl_line && pscl) begin
                if (bc == 8 && !tx_mode) tgt_low = (nbyte != nack_at);
                else if (tx_mode && bc < 8 && !last_nack) tgt_low = ~tx_bytes[nbyte-1][7-bc];
                else tgt_low = 1'b0;
            end
            pscl = scl_line; psda = sda_line;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0, b0, hcnt;
        logic ps, pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 7; a++) begin rd(3'(a), v); check("R1 register reset", v, 0); end
        check("R1 lines released", {30'b0, scl_oe, sda_oe}, 0);
        check("R1 irq low", {31'b0, irq}, 0);

        wr(3'd1, 32'h0000_01FF);       // divider 1, timeout on, length 127
        wr(3'd6, 32'h3);

        // R2 + R9: three-byte write, measure SCL high time
        start_write(7'h50, 32'h0033_2211, 3, 3);
        while (scl_line) @(negedge clk);
        while (!scl_line) @(negedge clk);
        hcnt = 0;
        while (scl_line) begin hcnt++; @(negedge clk); end
        check("R9 scl half period", hcnt, 16);
        wait_irq("R2");
        rd(3'd5, v); check("R2 done flag", v, 2);
        check("R2 queue drained", exp_q.size(), 0);
        wr(3'd5, 32'h0); rd(3'd5, v); check("R5 zero write keeps flag", v, 2);
        wr(3'd5, 32'h2); rd(3'd5, v); check("R5 w1c clears", v, 0);
        check("R5 irq drops", {31'b0, irq}, 0);

        // R4: NACK on second data byte of a four-byte write
        nack_at = 2;
        start_write(7'h21, 32'hA4A3_A2A1, 4, 2);
        wait_irq("R4");
        rd(3'd5, v); check("R4 data nack error", v, 1);
        check("R4 stopped after nack", exp_q.size(), 0);
        wr(3'd5, 32'h3);
        // R4: NACK on address
        nack_at = 0;
        start_write(7'h11, 32'h0000_00FF, 1, 0);
        wait_irq("R4");
        rd(3'd5, v); check("R4 address nack error", v, 1);
        wr(3'd5, 32'h3);
        nack_at = -1;

        // R3: four-byte read, ack pattern
        tx_bytes[0] = 8'hDE; tx_bytes[1] = 8'hAD; tx_bytes[2] = 8'hBE; tx_bytes[3] = 8'hEF;
        mack_v = '0;
        start_read(7'h3C, 4);
        wait_irq("R3");
        rd(3'd5, v); check("R3 read done", v, 2);
        rd(3'd4, v); check("R3 read word", v, 32'hEFBE_ADDE);
        check("R3 master ack pattern", {28'b0, mack_v}, 32'h7);
        wr(3'd5, 32'h3);
        tx_bytes[0] = 8'h5A;
        start_read(7'h3C, 1);
        wait_irq("R3");
        rd(3'd4, v); check("R3 single byte read", v, 32'h5A);
        wr(3'd5, 32'h3);

        // R5 masking
        wr(3'd6, 32'h0);
        start_write(7'h08, 32'h77, 1, 1);
        repeat (2000) @(negedge clk);
        rd(3'd5, v); check("R5 flag set while masked", v, 2);
        check("R5 masked irq low", {31'b0, irq}, 0);
        wr(3'd6, 32'h2);
        #1 check("R5 unmask raises irq", {31'b0, irq}, 1);
        wr(3'd5, 32'h3);

        // R7: start while disabled
        s0 = n_starts;
        wr(3'd0, GO | DIRW);
        repeat (600) @(negedge clk);
        check("R7 disabled start ignored", n_starts - s0, 0);
        rd(3'd0, v); check("R7 start bit reads zero", v, DIRW);
        rd(3'd5, v); check("R7 no flag when disabled", v, 0);

        // R7: start while busy
        s0 = n_starts; b0 = n_bytes;
        start_write(7'h2A, 32'h0000_6655, 2, 2);
        repeat (300) @(negedge clk);
        wr(3'd0, EN | GO | DIRW | 32'hC);
        wait_irq("R7");
        repeat (1000) @(negedge clk);
        check("R7 busy start ignored", n_starts - s0, 1);
        check("R7 byte count kept", n_bytes - b0, 3);
        wr(3'd5, 32'h3);

        // R6: clear of done in the same cycle it is set
        wr(3'd6, 32'h3);
        start_write(7'h44, 32'h99, 1, 1);
        ps = sda_line; pc = scl_line;
        forever begin
            @(negedge clk);
            if (scl_line && pc && sda_line && !ps) break;
            ps = sda_line; pc = scl_line;
        end
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h2;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        rd(3'd5, v); check("R6 set wins over clear", v, 2);
        check("R6 irq held", {31'b0, irq}, 1);
        wr(3'd5, 32'h3);

        // R8: SCL held low
        wr(3'd1, 32'h0000_0183);
        stretch = 1'b1;
        wr(3'd2, 32'h10); wr(3'd3, 32'h1);
        wr(3'd0, EN | GO | DIRW);
        wait_irq("R8");
        rd(3'd5, v); check("R8 timeout error", v, 1);
        stretch = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 lines released", {30'b0, scl_oe, sda_oe}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule